// File: doc/BRIEF.md
# USB Device IN Endpoint Controller

This block holds the control state of one IN endpoint of a USB device and picks the handshake to return for each IN token. The possible answers are a data packet, a zero-length packet, NAK or STALL. Software drives it through one-cycle control strobes: enable, request disable, set NAK, clear NAK, set stall and clear stall. Level inputs give the endpoint type (isochronous or not), the programmed transfer size and the maximum payload per packet. The link layer drives the token strobe, a corrupted-token qualifier, the transmit buffer fill level, a packet-finished strobe and an end-of-periodic-frame pulse.

The block counts the bytes sent across packets and closes the endpoint when the transfer size is reached. A disable request is finished by the hardware: it drops the pending-disable bit and raises a disabled interrupt. Three sticky interrupt flags are cleared by write-one-to-clear strobes. These flags report a token served while the buffer was short, a finished disable, and an isochronous transfer still open at the end of a frame. Packet encoding, CRC, the buffer memory and the flush logic belong to other blocks.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset the endpoint is disabled, NAK and stall are clear, no disable is pending, no response is valid, the response code is 2'b00, DMA fetch is off and all three interrupt flags are 0.
- R2: An accepted token (in_tok high, tok_bad low) gives resp_valid for exactly the following cycle. If the endpoint is enabled and idle, with NAK clear, no disable pending and fifo_level at least the packet length, resp_code is 2'b00 (data). The packet length is the smaller of pkt_size and the bytes still to send.
- R3: If the buffer holds less than the packet length, an isochronous endpoint answers 2'b01 (zero-length packet) and sets int_txfemp. A non-isochronous endpoint answers 2'b10 (NAK) and leaves the flag unchanged.
- R4: A token gets 2'b10 (NAK) when the endpoint is not enabled, when NAK is set, when a disable is pending, or when a data packet is still in flight. ctl_snak sets NAK, ctl_cnak clears it, and set wins if both are strobed together.
- R5: While stall is set on a non-isochronous endpoint, every token is answered 2'b11 (STALL), overriding NAK, until ctl_stall_clr clears it. On an isochronous endpoint the stall bit has no effect on the response.
- R6: A disable strobe sets disable_pending. With no packet in flight, disable_pending clears, ep_enabled drops and int_epdis sets two clock edges after the strobe. With a packet in flight, this happens on the edge after the one that samples pkt_done.
- R7: dma_en is high only while the endpoint is enabled and no disable is pending. It is low on the cycle after a disable strobe.
- R8: Each pkt_done during a data packet adds that packet's length to the sent-byte count. When the count reaches xfer_size, ep_enabled drops. ctl_enable_set enables the endpoint and resets the count to 0.
- R9: An end-of-frame pulse while an isochronous endpoint is enabled sets int_incomp. The pulse has no effect on a non-isochronous endpoint. A token with tok_bad high gets no response, so the transfer stays open.
- R10: The interrupt flags stay set until cleared by int_clr (bit 0 txfemp, bit 1 epdis, bit 2 incomp). A set event in the same cycle as a clear leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_iso | input | 1 | Endpoint type: 1 = isochronous |
| pkt_size | input | PKT_W | Maximum payload per packet, bytes |
| xfer_size | input | XFER_W | Programmed transfer size, bytes |
| ctl_enable_set | input | 1 | Enable endpoint, restart byte count |
| ctl_disable_set | input | 1 | Request endpoint disable |
| ctl_snak | input | 1 | Set NAK |
| ctl_cnak | input | 1 | Clear NAK |
| ctl_stall_set | input | 1 | Set stall |
| ctl_stall_clr | input | 1 | Clear stall |
| in_tok | input | 1 | IN token strobe |
| tok_bad | input | 1 | Token corrupted, qualifies in_tok |
| fifo_level | input | PKT_W | Bytes buffered for the next packet |
| pkt_done | input | 1 | Current data packet finished |
| frame_end | input | 1 | End of periodic frame pulse |
| int_clr | input | 3 | Write-one-to-clear strobes for the flags |
| resp_valid | output | 1 | Handshake response valid |
| resp_code | output | 2 | 00 data, 01 zero-length, 10 NAK, 11 STALL |
| dma_en | output | 1 | Payload fetch allowed |
| ep_enabled | output | 1 | Endpoint enabled |
| disable_pending | output | 1 | Disable request not yet finished |
| nak_on | output | 1 | NAK bit |
| stall_on | output | 1 | Stall bit |
| int_txfemp | output | 1 | Token served while buffer short |
| int_epdis | output | 1 | Endpoint disabled |
| int_incomp | output | 1 | Isochronous transfer incomplete at frame end |

## Verification
Every result is registered. The handshake, the control bits, the byte count and all flags change on the first edge that samples their stimulus. The disable handshake ends on the second edge after its strobe, or on the edge after pkt_done when a packet is in flight. The bench drives inputs just after a falling edge and updates a behavioural model on the rising edge. It compares every output with the model at the next falling edge, so each result is checked in the cycle it becomes due. Timed scenario checks also sample one or two falling edges after the stimulus, matching those delays.

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl #(
  parameter int PKT_W  = 11,
  parameter int XFER_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ep_iso,
  input  logic [PKT_W-1:0]  pkt_size,
  input  logic [XFER_W-1:0] xfer_size,
  input  logic              ctl_enable_set,
  input  logic              ctl_disable_set,
  input  logic              ctl_snak,
  input  logic              ctl_cnak,
  input  logic              ctl_stall_set,
  input  logic              ctl_stall_clr,
  input  logic              in_tok,
  input  logic              tok_bad,
  input  logic [PKT_W-1:0]  fifo_level,
  input  logic              pkt_done,
  input  logic              frame_end,
  input  logic [2:0]        int_clr,
  output logic              resp_valid,
  output logic [1:0]        resp_code,
  output logic              dma_en,
  output logic              ep_enabled,
  output logic              disable_pending,
  output logic              nak_on,
  output logic              stall_on,
  output logic              int_txfemp,
  output logic              int_epdis,
  output logic              int_incomp
);
  localparam logic [1:0] HS_DATA  = 2'b00;
  localparam logic [1:0] HS_ZLP   = 2'b01;
  localparam logic [1:0] HS_NAK   = 2'b10;
  localparam logic [1:0] HS_STALL = 2'b11;

  logic              busy_q;
  logic [XFER_W-1:0] sent_q;
  logic [PKT_W-1:0]  len_q;

  logic [XFER_W-1:0] remain;
  logic [PKT_W-1:0]  next_len;
  logic [XFER_W-1:0] sent_nx;
  logic              tok_ok, blocked, short_buf, dis_done, last_pkt;
  logic [1:0]        hs_nx;

  assign remain    = xfer_size - sent_q;
  assign next_len  = (remain > XFER_W'(pkt_size)) ? pkt_size : remain[PKT_W-1:0];
  assign tok_ok    = in_tok & ~tok_bad;
  assign blocked   = ~ep_enabled | nak_on | disable_pending | busy_q;
  assign short_buf = fifo_level < next_len;
  assign dis_done  = disable_pending & ~busy_q;
  assign sent_nx   = sent_q + XFER_W'(len_q);
  assign last_pkt  = busy_q & pkt_done & (sent_nx >= xfer_size);
  assign dma_en    = ep_enabled & ~disable_pending;

  always_comb begin
    if (stall_on & ~ep_iso)   hs_nx = HS_STALL;
    else if (blocked)         hs_nx = HS_NAK;
    else if (short_buf)       hs_nx = ep_iso ? HS_ZLP : HS_NAK;
    else                      hs_nx = HS_DATA;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid      <= 1'b0;
      resp_code       <= HS_DATA;
      ep_enabled      <= 1'b0;
      disable_pending <= 1'b0;
      nak_on          <= 1'b0;
      stall_on        <= 1'b0;
      int_txfemp      <= 1'b0;
      int_epdis       <= 1'b0;
      int_incomp      <= 1'b0;
      busy_q          <= 1'b0;
      sent_q          <= '0;
      len_q           <= '0;
    end else begin
      resp_valid <= tok_ok;
      if (tok_ok) resp_code <= hs_nx;

      if (ctl_snak)           nak_on <= 1'b1;
      else if (ctl_cnak)      nak_on <= 1'b0;
      if (ctl_stall_set)      stall_on <= 1'b1;
      else if (ctl_stall_clr) stall_on <= 1'b0;

      if (busy_q & pkt_done) begin
        busy_q <= 1'b0;
        sent_q <= sent_nx;
      end
      if (tok_ok && hs_nx == HS_DATA) begin
        busy_q <= 1'b1;
        len_q  <= next_len;
      end

      if (dis_done) ep_enabled <= 1'b0;
      else if (ctl_enable_set) begin
        ep_enabled <= 1'b1;
        sent_q     <= '0;
      end else if (last_pkt) ep_enabled <= 1'b0;

      if (dis_done)        disable_pending <= 1'b0;
      if (ctl_disable_set) disable_pending <= 1'b1;

      if (int_clr[0]) int_txfemp <= 1'b0;
      if (tok_ok && hs_nx == HS_ZLP) int_txfemp <= 1'b1;
      if (int_clr[1]) int_epdis <= 1'b0;
      if (dis_done)   int_epdis <= 1'b1;
      if (int_clr[2]) int_incomp <= 1'b0;
      if (frame_end & ep_enabled & ep_iso) int_incomp <= 1'b1;
    end
  end
endmodule

// File: rtl/usb_in_ep_ctrl_chk.sv
module usb_in_ep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ep_iso,
  input logic       in_tok,
  input logic       tok_bad,
  input logic       frame_end,
  input logic       ctl_disable_set,
  input logic       resp_valid,
  input logic [1:0] resp_code,
  input logic       dma_en,
  input logic       ep_enabled,
  input logic       disable_pending,
  input logic       stall_on,
  input logic       int_txfemp,
  input logic       int_epdis,
  input logic       int_incomp
);
  a_r2_resp_needs_token: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(in_tok && !tok_bad));

  a_r5_stall_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(stall_on && !ep_iso)) |-> resp_code == 2'b11);

  a_r5_iso_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(ep_iso)) |-> resp_code != 2'b11);

  a_r3_zlp_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code == 2'b01) |-> int_txfemp);

  a_r6_disabled_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_epdis) |-> (!ep_enabled && !disable_pending));

  a_r7_dma_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_disable_set) |-> !dma_en);

  a_r9_incomp_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_incomp) |-> $past(frame_end && ep_iso));
endmodule

bind usb_in_ep_ctrl usb_in_ep_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ep_iso(ep_iso), .in_tok(in_tok), .tok_bad(tok_bad),
  .frame_end(frame_end), .ctl_disable_set(ctl_disable_set),
  .resp_valid(resp_valid), .resp_code(resp_code), .dma_en(dma_en),
  .ep_enabled(ep_enabled), .disable_pending(disable_pending), .stall_on(stall_on),
  .int_txfemp(int_txfemp), .int_epdis(int_epdis), .int_incomp(int_incomp)
);

// File: tb/sim_usb_in_ep_ctrl.sv
`timescale 1ns/1ps
module sim_usb_in_ep_ctrl;
  localparam int PKT_W = 11;
  localparam int XFER_W = 19;

  logic clk = 0, rst_n = 0;
  logic ep_iso = 0;
  logic [PKT_W-1:0] pkt_size = 64;
  logic [XFER_W-1:0] xfer_size = 150;
  logic ctl_enable_set = 0, ctl_disable_set = 0, ctl_snak = 0, ctl_cnak = 0;
  logic ctl_stall_set = 0, ctl_stall_clr = 0;
  logic in_tok = 0, tok_bad = 0, pkt_done = 0, frame_end = 0;
  logic [PKT_W-1:0] fifo_level = 0;
  logic [2:0] int_clr = 0;
  logic resp_valid, dma_en, ep_enabled, disable_pending, nak_on, stall_on;
  logic int_txfemp, int_epdis, int_incomp;
  logic [1:0] resp_code;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  usb_in_ep_ctrl #(.PKT_W(PKT_W), .XFER_W(XFER_W)) u0 (.*);

  int m_rv, m_rc, m_en, m_dis, m_nak, m_stall, m_busy, m_sent, m_len;
  int m_txf, m_epd, m_inc;

  always @(posedge clk) begin
    int rem, ln, hs, n_en, n_sent, n_busy;
    bit tok, ddone;
    if (!rst_n) begin
      m_rv = 0; m_rc = 0; m_en = 0; m_dis = 0; m_nak = 0; m_stall = 0;
      m_busy = 0; m_sent = 0; m_len = 0; m_txf = 0; m_epd = 0; m_inc = 0;
    end else begin
      tok = in_tok && !tok_bad;
      rem = int'(xfer_size) - m_sent;
      ln = (rem > int'(pkt_size)) ? int'(pkt_size) : rem;
      if (m_stall && !ep_iso) hs = 3;
      else if (!m_en || m_nak || m_dis || m_busy) hs = 2;
      else if (int'(fifo_level) < ln) hs = ep_iso ? 1 : 2;
      else hs = 0;
      ddone = m_dis && !m_busy;
      n_en = m_en; n_sent = m_sent; n_busy = m_busy;
      if (m_busy && pkt_done) begin n_busy = 0; n_sent = m_sent + m_len; end
      if (ddone) n_en = 0;
      else if (ctl_enable_set) begin n_en = 1; n_sent = 0; end
      else if (m_busy && pkt_done && n_sent >= int'(xfer_size)) n_en = 0;
      if (tok && hs == 0) begin n_busy = 1; m_len = ln; end
      if (frame_end && m_en && ep_iso) m_inc = 1;
      else if (int_clr[2]) m_inc = 0;
      if (ddone) m_epd = 1; else if (int_clr[1]) m_epd = 0;
      if (tok && hs == 1) m_txf = 1; else if (int_clr[0]) m_txf = 0;
      m_rv = tok;
      if (tok) m_rc = hs;
      if (ctl_snak) m_nak = 1; else if (ctl_cnak) m_nak = 0;
      if (ctl_stall_set) m_stall = 1; else if (ctl_stall_clr) m_stall = 0;
      if (ctl_disable_set) m_dis = 1; else if (ddone) m_dis = 0;
      m_en = n_en; m_sent = n_sent; m_busy = n_busy;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("R2", "resp_valid", int'(resp_valid), m_rv);
    chk("R2", "resp_code", int'(resp_code), m_rc);
    chk("R7", "dma_en", int'(dma_en), (m_en && !m_dis) ? 1 : 0);
    chk("R8", "ep_enabled", int'(ep_enabled), m_en);
    chk("R6", "disable_pending", int'(disable_pending), m_dis);
    chk("R4", "nak_on", int'(nak_on), m_nak);
    chk("R5", "stall_on", int'(stall_on), m_stall);
    chk("R3", "int_txfemp", int'(int_txfemp), m_txf);
    chk("R6", "int_epdis", int'(int_epdis), m_epd);
    chk("R9", "int_incomp", int'(int_incomp), m_inc);
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_n) compare();
    end
  endtask

  task automatic token(bit bad = 0);
    in_tok = 1; tok_bad = bad; tick(); in_tok = 0; tok_bad = 0;
  endtask

  task automatic done_pkt();
    pkt_done = 1; tick(); pkt_done = 0;
  endtask

  task automatic enable();
    ctl_enable_set = 1; tick(); ctl_enable_set = 0;
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    chk("R1", "reset enabled", int'(ep_enabled), 0);
    chk("R1", "reset dma", int'(dma_en), 0);
    chk("R1", "reset resp", int'(resp_valid), 0);
    chk("R1", "reset code", int'(resp_code), 0);
    chk("R1", "reset flags", int'({int_txfemp, int_epdis, int_incomp}), 0);

    token();
    chk("R4", "disabled ep NAK", int'(resp_code), 2);

    fifo_level = 100;
    enable();
    chk("R7", "dma on when enabled", int'(dma_en), 1);
    token();
    chk("R2", "data valid", int'(resp_valid), 1);
    chk("R2", "data code", int'(resp_code), 0);
    token();
    chk("R4", "busy NAK", int'(resp_code), 2);
    done_pkt();
    token(); done_pkt();
    fifo_level = 10;
    token();
    chk("R3", "non-iso short NAK", int'(resp_code), 2);
    chk("R3", "non-iso no flag", int'(int_txfemp), 0);
    fifo_level = 22;
    token();
    chk("R2", "last short packet data", int'(resp_code), 0);
    done_pkt();
    chk("R8", "transfer complete closes ep", int'(ep_enabled), 0);

    enable();
    ctl_snak = 1; tick(); ctl_snak = 0;
    token();
    chk("R4", "nak set NAK", int'(resp_code), 2);
    ctl_stall_set = 1; tick(); ctl_stall_set = 0;
    token();
    chk("R5", "stall over nak", int'(resp_code), 3);
    tick(3);
    token();
    chk("R5", "stall held", int'(resp_code), 3);
    ctl_stall_clr = 1; tick(); ctl_stall_clr = 0;
    token();
    chk("R5", "stall cleared", int'(resp_code), 2);
    ctl_snak = 1; ctl_cnak = 1; tick(); ctl_snak = 0; ctl_cnak = 0;
    chk("R4", "snak wins", int'(nak_on), 1);
    ctl_cnak = 1; tick(); ctl_cnak = 0;

    ep_iso = 1;
    ctl_stall_set = 1; tick(); ctl_stall_set = 0;
    enable();
    fifo_level = 10;
    token();
    chk("R3", "iso short ZLP", int'(resp_code), 1);
    chk("R3", "iso short flag", int'(int_txfemp), 1);
    chk("R5", "iso ignores stall", int'(stall_on), 1);
    int_clr = 3'b001; tick(); int_clr = 0;
    chk("R10", "w1c txfemp", int'(int_txfemp), 0);
    int_clr = 3'b001; in_tok = 1; tick(); int_clr = 0; in_tok = 0;
    chk("R10", "set beats clear", int'(int_txfemp), 1);
    tick(2);
    chk("R10", "flag sticky", int'(int_txfemp), 1);
    ctl_stall_clr = 1; tick(); ctl_stall_clr = 0;

    token(1);
    chk("R9", "bad token no resp", int'(resp_valid), 0);
    frame_end = 1; tick(); frame_end = 0;
    chk("R9", "incomplete iso flag", int'(int_incomp), 1);
    int_clr = 3'b100; tick(); int_clr = 0;

    ctl_disable_set = 1; tick(); ctl_disable_set = 0;
    chk("R7", "dma off on disable", int'(dma_en), 0);
    chk("R6", "pending set", int'(disable_pending), 1);
    tick();
    chk("R6", "pending cleared", int'(disable_pending), 0);
    chk("R6", "epdis set", int'(int_epdis), 1);
    chk("R6", "ep disabled", int'(ep_enabled), 0);
    int_clr = 3'b010; tick(); int_clr = 0;

    ep_iso = 0; fifo_level = 100;
    enable();
    token();
    ctl_disable_set = 1; tick(); ctl_disable_set = 0;
    tick(3);
    chk("R6", "waits for packet", int'(disable_pending), 1);
    chk("R6", "no epdis yet", int'(int_epdis), 0);
    done_pkt();
    chk("R6", "still pending at done edge", int'(disable_pending), 1);
    tick();
    chk("R6", "done after packet", int'(int_epdis), 1);

    enable();
    frame_end = 1; tick(); frame_end = 0;
    chk("R9", "non-iso no incomp", int'(int_incomp), 0);
    tick(2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule